// File: doc/BRIEF.md
# Multi-Operand Carry-Save Adder Tree

This combinational block adds N unsigned operands. Each operand is IW bits wide, and the result is W bits wide. Each operand is first widened to W bits by filling the upper bits with zeros. The widened operands are then reduced to two W-bit vectors by layers of bitwise 3:2 full-adder compressors. One ordinary W-bit carry-propagate adder adds those two vectors to give the total, modulo 2^W. The two reduced vectors are also brought out as ports, so that a downstream stage can accept the redundant form directly.

The compressor network is fixed at elaboration from N. Every operand starts at depth 0. At each reduction level, only the operands whose depth is no greater than the level number may be grouped. They are grouped into consecutive triples in list order. Both outputs of a compressor take one more than the largest depth among its three inputs. After each level, the operand list is rebuilt in this order:

- the compressor outputs, sum before carry, group by group;
- the one or two ungrouped ready operands;
- the operands that had to wait.

A level with fewer than three ready operands adds no compressor. Reduction stops when two or fewer operands remain. Two constant outputs report how many compressors were built and the deepest compressor level.

Top module: `csa_tree_adder`

## Requirements
- R1: Each operand is zero-extended from IW to W bits. Its bits at positions IW and above count as 0 in every output.
- R2: `total_o` equals the sum of all N operands modulo 2^W, for any input pattern.
- R3: When the true sum exceeds 2^W - 1, the high bits are dropped and no error or saturation occurs.
- R4: `total_o` always equals `sum_o + carry_o` modulo 2^W.
- R5: When N is 3 or more, bit 0 of `carry_o` is always 0. Each compressor's carry vector is its majority vector shifted up one bit, with 0 entering at bit 0 and the top carry discarded.
- R6: With N = 0, `sum_o`, `carry_o` and `total_o` are all zero.
- R7: With N = 1, `sum_o` is the zero-extended operand and `carry_o` is zero.
- R8: With N = 2, `sum_o` is operand 0 and `carry_o` is operand 1, both zero-extended. No compressor is built.
- R9: `n_csa_o` reports the number of compressors: N - 2 when N is 3 or more, otherwise 0.
- R10: `depth_o` reports the deepest compressor level. It is 0, 0, 0, 1, 2, 4 and 4 for N = 0, 1, 2, 3, 4, 7 and 9.
- R11: Grouping follows list order. For N = 4, with operands a, b, c, d, the first compressor takes a, b, c. The second takes that compressor's sum, then its carry, then d. `sum_o` is the second compressor's sum and `carry_o` is its carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ops_i | input | max(N,1) x IW | Packed array of operands, word i at index i |
| sum_o | output | W | First reduced vector |
| carry_o | output | W | Second reduced vector |
| total_o | output | W | Final sum modulo 2^W |
| n_csa_o | output | CW | Number of compressors built (constant) |
| depth_o | output | CW | Deepest compressor level (constant) |

## Verification
The total does not depend on how the compressors are wired. The split of the result between `sum_o` and `carry_o`, however, shows the grouping order, and that order is hard to check from the total alone. A dedicated four-operand instance is driven with patterns in which the first triple produces nonzero carries. The bench then predicts both reduced vectors bit by bit from the stated grouping order, and compares them with the outputs. Separate instances cover zero, one, two, three and nine operands, so the degenerate paths and the modulo wrap are each reached from the ports.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;

  localparam int MAX_OPS   = 64;
  localparam int MAX_NODES = 3 * MAX_OPS;

  // Query selectors for the schedule function
  localparam int Q_IN0   = 0;
  localparam int Q_IN1   = 1;
  localparam int Q_IN2   = 2;
  localparam int Q_COUNT = 3;
  localparam int Q_DEPTH = 4;
  localparam int Q_OUT_A = 5;
  localparam int Q_OUT_B = 6;

  // Node numbering: operands are nodes 0..n-1.
  // Compressor k writes its sum to node n+2k and its carry to node n+2k+1.
  function automatic int sched_query(input int n, input int k, input int sel);
    int lst   [MAX_NODES];
    int dep   [MAX_NODES];
    int rdy   [MAX_NODES];
    int wt    [MAX_NODES];
    int nxt   [MAX_NODES];
    int cnt, nr, nw, nn, comp, maxd, res, used, id, d;
    for (int i = 0; i < MAX_NODES; i++) begin
      lst[i] = (i < n) ? i : 0;
      dep[i] = 0;
      rdy[i] = 0;
      wt[i]  = 0;
      nxt[i] = 0;
    end
    cnt  = n;
    comp = 0;
    maxd = 0;
    res  = -1;
    for (int lvl = 0; lvl < 2 * MAX_OPS; lvl++) begin
      if (cnt > 2) begin
        nr = 0;
        nw = 0;
        for (int j = 0; j < MAX_NODES; j++) begin
          if (j < cnt) begin
            if (dep[lst[j]] <= lvl) begin
              rdy[nr] = lst[j];
              nr++;
            end else begin
              wt[nw] = lst[j];
              nw++;
            end
          end
        end
        if (nr >= 3) begin
          nn   = 0;
          used = 0;
          for (int g = 0; g < MAX_NODES; g = g + 3) begin
            if (g + 2 < nr) begin
              id = n + 2 * comp;
              if (comp == k && sel <= Q_IN2) res = rdy[g + sel];
              d = dep[rdy[g]];
              if (dep[rdy[g + 1]] > d) d = dep[rdy[g + 1]];
              if (dep[rdy[g + 2]] > d) d = dep[rdy[g + 2]];
              d = d + 1;
              dep[id]     = d;
              dep[id + 1] = d;
              if (d > maxd) maxd = d;
              nxt[nn]     = id;
              nxt[nn + 1] = id + 1;
              nn   = nn + 2;
              comp = comp + 1;
              used = g + 3;
            end
          end
          for (int j = 0; j < MAX_NODES; j++) begin
            if (j >= used && j < nr) begin
              nxt[nn] = rdy[j];
              nn++;
            end
          end
          for (int j = 0; j < MAX_NODES; j++) begin
            if (j < nw) begin
              nxt[nn] = wt[j];
              nn++;
            end
          end
          for (int j = 0; j < MAX_NODES; j++) lst[j] = nxt[j];
          cnt = nn;
        end
      end
    end
    case (sel)
      Q_COUNT: res = comp;
      Q_DEPTH: res = maxd;
      Q_OUT_A: res = (cnt >= 1) ? lst[0] : -1;
      Q_OUT_B: res = (cnt >= 2) ? lst[1] : -1;
      default: ;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/csa_stage.sv
module csa_stage #(
  parameter int W = 12
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  logic [W-1:0] maj_w;

  assign sum_o   = a_i ^ b_i ^ c_i;
  assign maj_w   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  // Carry moves up one weight; bit 0 takes 0, the top carry drops out
  assign carry_o = maj_w << 1;

endmodule

// File: rtl/csa_final_add.sv
module csa_final_add #(
  parameter int W = 12
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);

  function automatic logic [W-1:0] ripple_add(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] r;
    logic         cy;
    cy = 1'b0;
    for (int i = 0; i < W; i++) begin
      r[i] = x[i] ^ y[i] ^ cy;
      cy   = (x[i] & y[i]) | (x[i] & cy) | (y[i] & cy);
    end
    return r;
  endfunction

  assign sum_o = ripple_add(a_i, b_i);

endmodule

// File: rtl/csa_tree_adder.sv
module csa_tree_adder #(
  parameter int N  = 7,
  parameter int IW = 8,
  parameter int W  = 12,
  parameter int CW = 8,
  localparam int ROWS = (N > 0) ? N : 1
) (
  input  logic [ROWS-1:0][IW-1:0] ops_i,
  output logic [W-1:0]            sum_o,
  output logic [W-1:0]            carry_o,
  output logic [W-1:0]            total_o,
  output logic [CW-1:0]           n_csa_o,
  output logic [CW-1:0]           depth_o
);

  import csa_tree_pkg::*;

  localparam int NCOMP   = sched_query(N, 0, Q_COUNT);
  localparam int DEPTH   = sched_query(N, 0, Q_DEPTH);
  localparam int NODES   = N + 2 * NCOMP;
  localparam int NODE_SZ = (NODES > 0) ? NODES : 1;
  localparam int IDX_A   = sched_query(N, 0, Q_OUT_A);
  localparam int IDX_B   = sched_query(N, 0, Q_OUT_B);

  function automatic logic [W-1:0] widen(input logic [IW-1:0] x);
    logic [W-1:0] r;
    r = '0;
    r[IW-1:0] = x;
    return r;
  endfunction

  logic [W-1:0] node [NODE_SZ];
  logic [W-1:0] red_a_w;
  logic [W-1:0] red_b_w;

  genvar gi;
  generate
    if (N == 0) begin : g_empty
      assign node[0] = '0;
    end
    for (gi = 0; gi < N; gi++) begin : g_in
      assign node[gi] = widen(ops_i[gi]);
    end
    for (gi = 0; gi < NCOMP; gi++) begin : g_csa
      localparam int IA = sched_query(N, gi, Q_IN0);
      localparam int IB = sched_query(N, gi, Q_IN1);
      localparam int IC = sched_query(N, gi, Q_IN2);
      csa_stage #(.W(W)) u_stage (
        .a_i     (node[IA]),
        .b_i     (node[IB]),
        .c_i     (node[IC]),
        .sum_o   (node[N + 2 * gi]),
        .carry_o (node[N + 2 * gi + 1])
      );
    end
    if (IDX_A >= 0) begin : g_ra
      assign red_a_w = node[IDX_A];
    end else begin : g_ra0
      assign red_a_w = '0;
    end
    if (IDX_B >= 0) begin : g_rb
      assign red_b_w = node[IDX_B];
    end else begin : g_rb0
      assign red_b_w = '0;
    end
  endgenerate

  csa_final_add #(.W(W)) u_cpa (
    .a_i   (red_a_w),
    .b_i   (red_b_w),
    .sum_o (total_o)
  );

  assign sum_o   = red_a_w;
  assign carry_o = red_b_w;
  assign n_csa_o = CW'(NCOMP);
  assign depth_o = CW'(DEPTH);

endmodule

// File: rtl/csa_tree_adder_chk.sv
module csa_tree_adder_chk #(
  parameter int N  = 7,
  parameter int IW = 8,
  parameter int W  = 12,
  parameter int CW = 8,
  localparam int ROWS = (N > 0) ? N : 1
) (
  input logic [ROWS-1:0][IW-1:0] ops_i,
  input logic [W-1:0]            sum_o,
  input logic [W-1:0]            carry_o,
  input logic [W-1:0]            total_o,
  input logic [CW-1:0]           n_csa_o,
  input logic [CW-1:0]           depth_o
);

  localparam int EXP_COMP = (N >= 3) ? N - 2 : 0;

  always_comb begin
    p_split_sums_to_total_r4: assert (total_o == (sum_o + carry_o))
      else $error("total differs from sum+carry");
    p_count_r9: assert (n_csa_o == CW'(EXP_COMP))
      else $error("compressor count wrong");
    if (N >= 3) begin
      p_carry_lsb_zero_r5: assert (carry_o[0] == 1'b0)
        else $error("carry bit 0 set");
    end
    if (N < 3) begin
      p_no_depth_r10: assert (depth_o == '0)
        else $error("depth nonzero without compressors");
    end
    if (N == 0) begin
      p_empty_zero_r6: assert (sum_o == '0 && carry_o == '0 && total_o == '0)
        else $error("empty tree not zero");
    end
    if (N == 1) begin
      p_single_pass_r7: assert (carry_o == '0 && sum_o[IW-1:0] == ops_i[0] && (sum_o >> IW) == '0)
        else $error("single operand not passed");
    end
    if (N == 2) begin
      p_pair_pass_r8: assert (sum_o[IW-1:0] == ops_i[0] && carry_o[IW-1:0] == ops_i[ROWS-1]
                              && (sum_o >> IW) == '0 && (carry_o >> IW) == '0)
        else $error("pair not passed");
    end
  end

endmodule

bind csa_tree_adder csa_tree_adder_chk #(.N(N), .IW(IW), .W(W), .CW(CW)) u_chk (
  .ops_i   (ops_i),
  .sum_o   (sum_o),
  .carry_o (carry_o),
  .total_o (total_o),
  .n_csa_o (n_csa_o),
  .depth_o (depth_o)
);

// File: tb/csa_tree_adder_bench.sv
module csa_tree_adder_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // default instance: N=7, IW=8, W=12
  logic [6:0][7:0] op7 = '0;
  logic [11:0] s7, c7, t7;
  logic [7:0]  k7, d7;
  csa_tree_adder u_csa_tree_adder (.ops_i(op7), .sum_o(s7), .carry_o(c7), .total_o(t7), .n_csa_o(k7), .depth_o(d7));

  logic [0:0][7:0] op0 = '0;
  logic [11:0] s0, c0, t0;
  logic [7:0]  k0, d0;
  csa_tree_adder #(.N(0)) u_n0 (.ops_i(op0), .sum_o(s0), .carry_o(c0), .total_o(t0), .n_csa_o(k0), .depth_o(d0));

  logic [0:0][5:0] op1 = '0;
  logic [9:0] s1, c1, t1;
  logic [7:0] k1, d1;
  csa_tree_adder #(.N(1), .IW(6), .W(10)) u_n1 (.ops_i(op1), .sum_o(s1), .carry_o(c1), .total_o(t1), .n_csa_o(k1), .depth_o(d1));

  logic [1:0][7:0] op2 = '0;
  logic [9:0] s2, c2, t2;
  logic [7:0] k2, d2;
  csa_tree_adder #(.N(2), .W(10)) u_n2 (.ops_i(op2), .sum_o(s2), .carry_o(c2), .total_o(t2), .n_csa_o(k2), .depth_o(d2));

  logic [2:0][7:0] op3 = '0;
  logic [11:0] s3, c3, t3;
  logic [7:0]  k3, d3;
  csa_tree_adder #(.N(3)) u_n3 (.ops_i(op3), .sum_o(s3), .carry_o(c3), .total_o(t3), .n_csa_o(k3), .depth_o(d3));

  logic [3:0][7:0] op4 = '0;
  logic [7:0] s4, c4, t4, k4, d4;
  csa_tree_adder #(.N(4), .W(8)) u_n4 (.ops_i(op4), .sum_o(s4), .carry_o(c4), .total_o(t4), .n_csa_o(k4), .depth_o(d4));

  logic [8:0][7:0] op9 = '0;
  logic [7:0] s9, c9, t9, k9, d9;
  csa_tree_adder #(.N(9), .W(8)) u_n9 (.ops_i(op9), .sum_o(s9), .carry_o(c9), .total_o(t9), .n_csa_o(k9), .depth_o(d9));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] add_words(input logic [31:0] w [], input int mod_bits);
    logic [31:0] acc = 0;
    foreach (w[i]) acc += w[i];
    return acc & ((32'd1 << mod_bits) - 1);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R2 idle total", 32'(t7), 0);
    chk("R2 idle sum", 32'(s7), 0);
    chk("R2 idle carry", 32'(c7), 0);
  endtask

  task automatic t_counts();
    @(negedge clk);
    chk("R9 count N0", 32'(k0), 0);  chk("R10 depth N0", 32'(d0), 0);
    chk("R9 count N1", 32'(k1), 0);  chk("R10 depth N1", 32'(d1), 0);
    chk("R9 count N2", 32'(k2), 0);  chk("R10 depth N2", 32'(d2), 0);
    chk("R9 count N3", 32'(k3), 1);  chk("R10 depth N3", 32'(d3), 1);
    chk("R9 count N4", 32'(k4), 2);  chk("R10 depth N4", 32'(d4), 2);
    chk("R9 count N7", 32'(k7), 5);  chk("R10 depth N7", 32'(d7), 4);
    chk("R9 count N9", 32'(k9), 7);  chk("R10 depth N9", 32'(d9), 4);
  endtask

  task automatic t_random();
    for (int v = 0; v < 24; v++) begin
      logic [31:0] w7 [] = new[7];
      logic [31:0] w3 [] = new[3];
      logic [31:0] w9 [] = new[9];
      @(posedge clk);
      for (int i = 0; i < 7; i++) begin op7[i] = 8'($urandom); w7[i] = 32'(op7[i]); end
      for (int i = 0; i < 3; i++) begin op3[i] = 8'($urandom); w3[i] = 32'(op3[i]); end
      for (int i = 0; i < 9; i++) begin op9[i] = 8'($urandom); w9[i] = 32'(op9[i]); end
      @(negedge clk);
      chk("R2 total N7", 32'(t7), add_words(w7, 12));
      chk("R2 total N3", 32'(t3), add_words(w3, 12));
      chk("R3 total N9 wrap", 32'(t9), add_words(w9, 8));
      chk("R4 split N7", 32'(12'(s7 + c7)), 32'(t7));
      chk("R5 carry lsb N7", 32'(c7[0]), 0);
      chk("R5 carry lsb N9", 32'(c9[0]), 0);
    end
  endtask

  task automatic t_allones();
    @(posedge clk);
    op7 = '1;
    op9 = '1;
    op3 = '1;
    @(negedge clk);
    chk("R1 all ones N7 no upper garbage", 32'(t7), 1785);
    chk("R3 all ones N9 wraps", 32'(t9), 247);
    chk("R1 all ones N3", 32'(t3), 765);
  endtask

  task automatic t_empty();
    @(posedge clk);
    op0 = '1;
    @(negedge clk);
    chk("R6 empty sum", 32'(s0), 0);
    chk("R6 empty carry", 32'(c0), 0);
    chk("R6 empty total", 32'(t0), 0);
  endtask

  task automatic t_single();
    @(posedge clk);
    op1[0] = 6'h3F;
    @(negedge clk);
    chk("R7 single sum", 32'(s1), 32'h3F);
    chk("R7 single carry", 32'(c1), 0);
    chk("R1 single total zero-extended", 32'(t1), 32'h3F);
  endtask

  task automatic t_pair();
    @(posedge clk);
    op2[0] = 8'hF0;
    op2[1] = 8'h3C;
    @(negedge clk);
    chk("R8 pair sum", 32'(s2), 32'hF0);
    chk("R8 pair carry", 32'(c2), 32'h3C);
    chk("R8 pair total", 32'(t2), 32'h12C);
  endtask

  task automatic t_order();
    logic [7:0] a, b, c, d, x1, y1, x2, y2;
    for (int v = 0; v < 6; v++) begin
      @(posedge clk);
      a = (v == 0) ? 8'hFF : 8'($urandom);
      b = (v == 0) ? 8'h0F : 8'($urandom);
      c = (v == 0) ? 8'h33 : 8'($urandom);
      d = (v == 0) ? 8'h81 : 8'($urandom);
      op4[0] = a; op4[1] = b; op4[2] = c; op4[3] = d;
      x1 = a ^ b ^ c;
      y1 = 8'(((a & b) | (a & c) | (b & c)) << 1);
      x2 = x1 ^ y1 ^ d;
      y2 = 8'(((x1 & y1) | (x1 & d) | (y1 & d)) << 1);
      @(negedge clk);
      chk("R11 order sum", 32'(s4), 32'(x2));
      chk("R11 order carry", 32'(c4), 32'(y2));
      chk("R2 total N4", 32'(t4), 32'(8'(a + b + c + d)));
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin
    t_reset();
    t_counts();
    t_random();
    t_allones();
    t_empty();
    t_single();
    t_pair();
    t_order();
    done = 1;
    summary();
  end

endmodule